// File: doc/BRIEF.md
# Hysteretic Brightness Code Quantizer

This block turns a digitised control level, given as an unsigned fraction of a full-scale value, into a steady 5-bit brightness code from 0 to 31. It keeps its present code and moves it only when the input crosses a threshold on a 33-step grid. That threshold depends on the code now held. The band between the rising and falling thresholds is one code wide, so an input that sits near a boundary does not make the output toggle between two neighbouring codes.

A scale-select input chooses the direction of the scale. In positive scale, zero input means the lowest brightness. In negative scale the grid is mirrored, so zero input means the highest brightness. Each update strobe moves the code by at most one step, so after a large change of input the code walks to its new value over several strobes. The code stops at 0 and at 31. All threshold tests are integer multiply-and-compare operations, with no division.

Top module: `brightness_quantizer`

## Requirements
- R1: After reset the code is 0.
- R2: In positive scale (scale_neg = 0), with present code n, a strobe whose input x satisfies x·33 ≥ (n+2)·FULL_SCALE raises the code by one.
- R3: In positive scale, a strobe with x·33 ≤ n·FULL_SCALE lowers the code by one.
- R4: In negative scale (scale_neg = 1), a strobe with x·33 ≤ (31−n)·FULL_SCALE raises the code by one.
- R5: In negative scale, a strobe with x·33 ≥ (33−n)·FULL_SCALE lowers the code by one.
- R6: A strobe whose input lies strictly between the falling and rising thresholds of the present code leaves the code unchanged.
- R7: The code changes by at most one step per strobe, and it does not change in a cycle without a strobe.
- R8: The code saturates: it never goes above 31 or below 0, and it never wraps from one end to the other.
- R9: The new code appears on bright_code LATENCY = 1 + REG_IN rising edges after the edge that samples the strobe. An input above FULL_SCALE is treated as FULL_SCALE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_strobe | input | 1 | One-cycle pulse: evaluate sample_value and scale_neg |
| sample_value | input | IN_W | Unsigned control level; FULL_SCALE means 100 % |
| scale_neg | input | 1 | 0 = positive scale, 1 = negative (mirrored) scale |
| bright_code | output | 5 | Registered brightness code, 0 to 31 |

## Verification
The bench runs with REG_IN = 1. A strobe therefore reaches bright_code two rising edges after it is driven: one edge for the input stage register and one for the code register. The bench drives each strobe at a falling edge. It samples the code at the falling edge after the second rising edge. In the latency test it also samples at the falling edge between the two rising edges, where the old code must still be present. Saturation and the no-strobe case are checked after long runs of strobes, or after idle cycles with the input held at an extreme value.

// File: rtl/bq_pkg.sv
`timescale 1ns/1ps
package bq_pkg;
   localparam int unsigned CODE_W   = 5;
   localparam int unsigned CODE_MAX = (1 << CODE_W) - 1;
   localparam int unsigned GRID     = CODE_MAX + 2;   // 33-step threshold grid
   localparam int unsigned GRID_W   = 6;              // bits to hold GRID

   typedef logic [CODE_W-1:0] code_t;

   typedef enum logic {
      SCALE_POS = 1'b0,
      SCALE_NEG = 1'b1
   } scale_e;
endpackage

// File: rtl/bq_input_stage.sv
`timescale 1ns/1ps
module bq_input_stage #(
   parameter int unsigned IN_W       = 10,
   parameter int unsigned FULL_SCALE = (1 << IN_W) - 1,
   parameter bit          REG_IN     = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            strobe_i,
   input  logic [IN_W-1:0] value_i,
   input  logic            scale_neg_i,
   output logic            valid_o,
   output logic [IN_W-1:0] level_o
);
   import bq_pkg::*;

   localparam logic [IN_W-1:0] FS_V = IN_W'(FULL_SCALE);

   logic [IN_W-1:0] clamped;
   logic [IN_W-1:0] folded;

   // Clamp to full scale, then fold the negative scale onto the positive one.
   always_comb begin
      clamped = (value_i > FS_V) ? FS_V : value_i;
      folded  = (scale_e'(scale_neg_i) == SCALE_NEG) ? (FS_V - clamped) : clamped;
   end

   generate
      if (REG_IN) begin : g_reg
         logic            valid_q;
         logic [IN_W-1:0] level_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               valid_q <= 1'b0;
               level_q <= '0;
            end else begin
               valid_q <= strobe_i;
               if (strobe_i) level_q <= folded;
            end
         end
         assign valid_o = valid_q;
         assign level_o = level_q;
      end else begin : g_comb
         assign valid_o = strobe_i;
         assign level_o = folded;
      end
   endgenerate
endmodule

// File: rtl/bq_threshold.sv
`timescale 1ns/1ps
module bq_threshold #(
   parameter int unsigned IN_W       = 10,
   parameter int unsigned FULL_SCALE = (1 << IN_W) - 1
) (
   input  bq_pkg::code_t   code_i,
   input  logic [IN_W-1:0] level_i,
   output logic            rise_o,
   output logic            fall_o
);
   import bq_pkg::*;

   localparam int unsigned PW = IN_W + GRID_W;

   logic [PW-1:0] scaled;
   logic [PW-1:0] rise_lim;
   logic [PW-1:0] fall_lim;

   always_comb begin
      scaled   = PW'(level_i) * PW'(GRID);
      rise_lim = (PW'(code_i) + PW'(2)) * PW'(FULL_SCALE);
      fall_lim = PW'(code_i) * PW'(FULL_SCALE);
      rise_o   = (scaled >= rise_lim);
      fall_o   = (scaled <= fall_lim);
   end
endmodule

// File: rtl/bq_code_reg.sv
`timescale 1ns/1ps
module bq_code_reg (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          valid_i,
   input  logic          rise_i,
   input  logic          fall_i,
   output bq_pkg::code_t code_o
);
   import bq_pkg::*;

   localparam code_t TOP = code_t'(CODE_MAX);

   code_t code_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q <= '0;
      end else if (valid_i) begin
         if (rise_i && (code_q != TOP))
            code_q <= code_q + code_t'(1);
         else if (fall_i && (code_q != '0))
            code_q <= code_q - code_t'(1);
      end
   end

   assign code_o = code_q;
endmodule

// File: rtl/brightness_quantizer.sv
`timescale 1ns/1ps
module brightness_quantizer #(
   parameter int unsigned IN_W       = 10,
   parameter int unsigned FULL_SCALE = (1 << IN_W) - 1,
   parameter bit          REG_IN     = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sample_strobe,
   input  logic [IN_W-1:0] sample_value,
   input  logic            scale_neg,
   output logic [4:0]      bright_code
);
   import bq_pkg::*;

   localparam int unsigned LATENCY = 1 + (REG_IN ? 1 : 0);

   generate
      if (IN_W < 2 || IN_W > 24) begin : g_bad_width
         $error("brightness_quantizer: IN_W must be 2..24");
      end
      if (FULL_SCALE == 0 || FULL_SCALE >= (1 << IN_W)) begin : g_bad_scale
         $error("brightness_quantizer: FULL_SCALE must be 1..2**IN_W-1");
      end
      if (LATENCY < 1) begin : g_bad_lat
         $error("brightness_quantizer: latency underflow");
      end
   endgenerate

   logic            stg_valid;
   logic [IN_W-1:0] stg_x;
   logic            step_up;
   logic            step_dn;
   code_t           code;

   bq_input_stage #(
      .IN_W(IN_W), .FULL_SCALE(FULL_SCALE), .REG_IN(REG_IN)
   ) u_stage (
      .clk(clk), .rst_n(rst_n),
      .strobe_i(sample_strobe), .value_i(sample_value), .scale_neg_i(scale_neg),
      .valid_o(stg_valid), .level_o(stg_x)
   );

   bq_threshold #(
      .IN_W(IN_W), .FULL_SCALE(FULL_SCALE)
   ) u_thresh (
      .code_i(code), .level_i(stg_x), .rise_o(step_up), .fall_o(step_dn)
   );

   bq_code_reg u_code (
      .clk(clk), .rst_n(rst_n), .valid_i(stg_valid),
      .rise_i(step_up), .fall_i(step_dn), .code_o(code)
   );

   assign bright_code = code;
endmodule

// File: rtl/brightness_quantizer_checker.sv
`timescale 1ns/1ps
module brightness_quantizer_checker #(
   parameter int unsigned IN_W       = 10,
   parameter int unsigned FULL_SCALE = (1 << IN_W) - 1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            stg_valid,
   input logic [IN_W-1:0] stg_x,
   input logic [4:0]      code
);
   localparam int unsigned PW = IN_W + 6;

   logic [PW-1:0] lvl33;
   logic [PW-1:0] up_edge;
   logic [PW-1:0] dn_edge;
   logic          want_up;
   logic          in_band;

   always_comb begin
      lvl33   = PW'(stg_x) * PW'(33);
      up_edge = (PW'(code) + PW'(2)) * PW'(FULL_SCALE);
      dn_edge = PW'(code) * PW'(FULL_SCALE);
      want_up = stg_valid && (code != 5'd31) && (lvl33 >= up_edge);
      in_band = stg_valid && (lvl33 < up_edge) && (lvl33 > dn_edge);
   end

   // R1
   a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> code == 5'd0);

   // R2
   a_r2_step_up: assert property (@(posedge clk) disable iff (!rst_n)
      want_up |=> code == $past(code) + 5'd1);

   // R6
   a_r6_band_hold: assert property (@(posedge clk) disable iff (!rst_n)
      in_band |=> $stable(code));

   // R7
   a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(stg_valid) |-> $stable(code));

   // R7
   a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      $past(stg_valid) |-> (code == $past(code) || code == $past(code) + 5'd1
                            || code == $past(code) - 5'd1));

   // R8
   a_r8_no_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
      $past(code) == 5'd31 |-> code != 5'd0);

   // R8
   a_r8_no_wrap_bottom: assert property (@(posedge clk) disable iff (!rst_n)
      $past(code) == 5'd0 |-> code != 5'd31);
endmodule

bind brightness_quantizer brightness_quantizer_checker #(
   .IN_W(IN_W), .FULL_SCALE(FULL_SCALE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .stg_valid(stg_valid), .stg_x(stg_x), .code(code)
);

// File: tb/brightness_quantizer_bench.sv
`timescale 1ns/1ps
module brightness_quantizer_bench;
   localparam int unsigned IN_W = 11;
   localparam int unsigned FS   = 1023;   // 1023 = 33*31: thresholds at multiples of 31
   localparam int unsigned LAT  = 2;

   typedef struct packed {
      logic [10:0] x;
      logic        neg;
      logic [4:0]  exp;
   } vec_t;

   // Each row is one strobe, applied in order from code 0; exp is the code after it.
   localparam vec_t VECS [15] = '{
      '{11'd62,   1'b0, 5'd1},  // R2 rise at 62 from 0
      '{11'd62,   1'b0, 5'd1},  // R6 hold inside band at 1
      '{11'd93,   1'b0, 5'd2},  // R2 rise at 93
      '{11'd92,   1'b0, 5'd2},  // R6 just below rising edge
      '{11'd62,   1'b0, 5'd1},  // R3 fall at 62 from 2
      '{11'd1023, 1'b0, 5'd2},  // R7 one step only
      '{11'd1023, 1'b0, 5'd3},  // R7 one step only
      '{11'd0,    1'b0, 5'd2},  // R3 one step down
      '{11'd0,    1'b1, 5'd3},  // R4 zero input is bright in negative scale
      '{11'd899,  1'b1, 5'd3},  // R6 negative band hold
      '{11'd930,  1'b1, 5'd2},  // R5 fall at 930 from 3
      '{11'd868,  1'b1, 5'd3},  // R4 rise at 899 limit from 2
      '{11'd1023, 1'b1, 5'd2},  // R5
      '{11'd2000, 1'b0, 5'd3},  // R9 clamp to full scale, positive
      '{11'd2000, 1'b1, 5'd2}   // R9 clamp to full scale, negative
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            sample_strobe = 1'b0;
   logic [IN_W-1:0] sample_value = '0;
   logic            scale_neg = 1'b0;
   logic [4:0]      bright_code;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   brightness_quantizer #(.IN_W(IN_W), .FULL_SCALE(FS), .REG_IN(1'b1)) u_brightness_quantizer (
      .clk(clk), .rst_n(rst_n), .sample_strobe(sample_strobe),
      .sample_value(sample_value), .scale_neg(scale_neg), .bright_code(bright_code)
   );

   task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: code=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [IN_W-1:0] x, input logic neg);
      sample_value  = x;
      scale_neg     = neg;
      sample_strobe = 1'b1;
      @(negedge clk);
      sample_strobe = 1'b0;
      repeat (LAT - 1) @(negedge clk);
   endtask

   initial begin
      #4000000;
      errors++;
      $display("FAIL watchdog: code=%0d expected=done", bright_code);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset", bright_code, 5'd0);

      for (int i = 0; i < 15; i++) begin
         apply(VECS[i].x, VECS[i].neg);
         check($sformatf("R2-table row %0d", i), bright_code, VECS[i].exp);
      end

      // R9 latency: code at 2, positive strobe at 1023 -> 3 after two edges
      sample_value = 11'd1023; scale_neg = 1'b0; sample_strobe = 1'b1;
      @(negedge clk);
      sample_strobe = 1'b0;
      check("R9 old code one edge after strobe", bright_code, 5'd2);
      @(negedge clk);
      check("R9 new code two edges after strobe", bright_code, 5'd3);

      // R7 no strobe: extreme input held, no change
      sample_value = 11'd1023;
      repeat (10) @(negedge clk);
      check("R7 idle cycles keep code", bright_code, 5'd3);

      // R8 top saturation
      for (int k = 0; k < 40; k++) apply(11'd1023, 1'b0);
      check("R8 saturate at 31", bright_code, 5'd31);
      apply(11'd1023, 1'b0);
      check("R8 stays 31", bright_code, 5'd31);

      // R6 / R3 at top of grid: falling edge of 31 is 961
      apply(11'd962, 1'b0);
      check("R6 hold at 31", bright_code, 5'd31);
      apply(11'd961, 1'b0);
      check("R3 fall from 31", bright_code, 5'd30);

      // R8 bottom saturation through negative scale
      for (int k = 0; k < 40; k++) apply(11'd1023, 1'b1);
      check("R8 saturate at 0", bright_code, 5'd0);
      apply(11'd1023, 1'b1);
      check("R8 stays 0", bright_code, 5'd0);

      // R4 at the bottom: n=0 rises when x <= 961
      apply(11'd961, 1'b1);
      check("R4 rise from 0", bright_code, 5'd1);

      // R1 reset mid-run
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset after run", bright_code, 5'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule